// File: doc/BRIEF.md
# Queue Threshold Level Monitor

This block keeps the threshold settings and the level reporting for a programmed-I/O queue interface. It watches the current fill levels of five queues: command slots, responses, in-band interrupt status, transmit data and receive data. It compares each level with a threshold that software writes, and it drives five level flags toward the interrupt status logic. The queues themselves, the data ports and the interrupt masking sit outside this block.

Software sees five 32-bit registers through a simple write-strobe and combinational read path. The size register reports the capacities fixed at elaboration. The queue threshold register holds plain entry counts. The data threshold register holds power-of-two exponent codes. Two read-only status registers report the live levels. A free-slot count drives the command flag. The other queue flags compare filled entries.

Top module: `qlevel_mon`

## Requirements
- R1: After reset, the queue threshold register (offset 0x10) reads 0x01010101 and the data threshold register (offset 0x14) reads 0.
- R2: Offset 0x10 stores all 32 written bits as four bytes: IBI status threshold at 31:24, IBI data threshold at 23:16, response threshold at 15:8, command free-slot threshold at 7:0. Offset 0x14 stores only its four 3-bit fields: RX start at 26:24, TX start at 18:16, RX threshold code at 10:8 and TX threshold code at 2:0. All other bits of 0x14 read as zero.
- R3: The size register (offset 0x18) reads TX size code at 31:24, RX size code at 23:16, IBI status entries at 15:8 and command/response depth at 7:0, all taken from parameters. A write to it changes nothing.
- R4: Offset 0x38 reads IBI level at 28:20, response level at 18:10 and command free slots at 8:0. Offset 0x3C reads RX level at 26:16 and TX level at 10:0.
- R5: cmd_rdy is 1 exactly when cmd_free_lvl is at least the command threshold.
- R6: resp_rdy is 1 exactly when resp_lvl is at least the response threshold.
- R7: ibi_hit is 1 exactly when ibi_lvl is at least the IBI status threshold (bits 31:24). The IBI data threshold byte has no effect on any flag.
- R8: A queue threshold byte of zero acts as one, so an empty queue never raises cmd_rdy, resp_rdy or ibi_hit.
- R9: rx_hit is 1 exactly when rx_lvl is at least 2^c, where c is the RX threshold code.
- R10: tx_hit is 1 exactly when the TX free space is at least 2^c, where c is the TX threshold code. Free space is 2^(s+1) minus tx_lvl for TX size code s, and it is zero when tx_lvl reaches or exceeds that capacity.
- R11: The flags follow the level inputs in the same cycle. A threshold write takes effect from the clock edge that accepts it.
- R12: Unmapped offsets read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cmd_free_lvl | input | QLW | Free command slots |
| resp_lvl | input | QLW | Filled response entries |
| ibi_lvl | input | QLW | Filled IBI status entries |
| tx_lvl | input | DLW | Filled TX data words |
| rx_lvl | input | DLW | Filled RX data words |
| cmd_rdy | output | 1 | Command free-slot threshold reached |
| resp_rdy | output | 1 | Response threshold reached |
| ibi_hit | output | 1 | IBI status threshold reached |
| tx_hit | output | 1 | TX free-space threshold reached |
| rx_hit | output | 1 | RX fill threshold reached |

## Verification
A threshold write and a change of the level it guards can land in the same cycle. The bench provokes this by raising the response threshold from one to four while it drops the response level to three in the same cycle. Before the edge, the flag must follow the new level against the old threshold and read 1. After the edge, it must read 0 against the new threshold. Random traffic also mixes threshold writes with level changes, and a bench model judges every flag.

// File: rtl/qlevel_mon.sv
module qlevel_mon #(
  parameter int TX_SZ_CODE  = 5,
  parameter int RX_SZ_CODE  = 4,
  parameter int IBI_ENTRIES = 16,
  parameter int CR_ENTRIES  = 8,
  parameter int QLW         = 9,
  parameter int DLW         = 11,
  parameter int AW          = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic [QLW-1:0] cmd_free_lvl,
  input  logic [QLW-1:0] resp_lvl,
  input  logic [QLW-1:0] ibi_lvl,
  input  logic [DLW-1:0] tx_lvl,
  input  logic [DLW-1:0] rx_lvl,
  output logic           cmd_rdy,
  output logic           resp_rdy,
  output logic           ibi_hit,
  output logic           tx_hit,
  output logic           rx_hit
);

  localparam logic [AW-1:0] A_QTHR = AW'('h10);
  localparam logic [AW-1:0] A_DTHR = AW'('h14);
  localparam logic [AW-1:0] A_SIZE = AW'('h18);
  localparam logic [AW-1:0] A_QLVL = AW'('h38);
  localparam logic [AW-1:0] A_DLVL = AW'('h3C);
  localparam logic [31:0]   TX_CAP = 32'd2 << TX_SZ_CODE;
  localparam logic [31:0]   SIZE_WORD = {8'(TX_SZ_CODE), 8'(RX_SZ_CODE),
                                         8'(IBI_ENTRIES), 8'(CR_ENTRIES)};

  logic [31:0] q_thr;
  logic [2:0]  rx_start, tx_start, rx_code, tx_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_thr    <= 32'h0101_0101;
      rx_start <= '0;
      tx_start <= '0;
      rx_code  <= '0;
      tx_code  <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_QTHR) q_thr <= reg_wdata;
      if (reg_addr == A_DTHR) begin
        rx_start <= reg_wdata[26:24];
        tx_start <= reg_wdata[18:16];
        rx_code  <= reg_wdata[10:8];
        tx_code  <= reg_wdata[2:0];
      end
    end
  end

  function automatic logic [8:0] eff_thr(input logic [7:0] t);
    return (t == 8'd0) ? 9'd1 : {1'b0, t};
  endfunction

  logic [8:0]  cmd9, resp9, ibi9;
  logic [10:0] tx11, rx11;
  logic [31:0] tx_free, tx_need, rx_need;

  assign cmd9  = 9'(cmd_free_lvl);
  assign resp9 = 9'(resp_lvl);
  assign ibi9  = 9'(ibi_lvl);
  assign tx11  = 11'(tx_lvl);
  assign rx11  = 11'(rx_lvl);

  assign tx_free = (32'(tx_lvl) >= TX_CAP) ? 32'd0 : TX_CAP - 32'(tx_lvl);
  assign tx_need = 32'd1 << tx_code;
  assign rx_need = 32'd1 << rx_code;

  assign cmd_rdy  = cmd9  >= eff_thr(q_thr[7:0]);
  assign resp_rdy = resp9 >= eff_thr(q_thr[15:8]);
  assign ibi_hit  = ibi9  >= eff_thr(q_thr[31:24]);
  assign tx_hit   = tx_free >= tx_need;
  assign rx_hit   = 32'(rx_lvl) >= rx_need;

  always_comb begin
    case (reg_addr)
      A_QTHR:  reg_rdata = q_thr;
      A_DTHR:  reg_rdata = {5'd0, rx_start, 5'd0, tx_start, 5'd0, rx_code, 5'd0, tx_code};
      A_SIZE:  reg_rdata = SIZE_WORD;
      A_QLVL:  reg_rdata = {3'd0, ibi9, 1'b0, resp9, 1'b0, cmd9};
      A_DLVL:  reg_rdata = {5'd0, rx11, 5'd0, tx11};
      default: reg_rdata = 32'd0;
    endcase
  end

  a_r8_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_free_lvl == '0) |-> !cmd_rdy);
  a_r8_empty_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_lvl == '0) |-> !resp_rdy);
  a_r9_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl == '0) |-> !rx_hit);
  a_r10_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_lvl) >= TX_CAP) |-> !tx_hit);
  a_r11_qthr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_QTHR) |=> (q_thr == $past(reg_wdata)));
  a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != A_QTHR && reg_addr != A_DTHR) |=>
      ($stable(q_thr) && $stable(rx_code) && $stable(tx_code)
       && $stable(rx_start) && $stable(tx_start)));

endmodule

// File: tb/sim_qlevel_mon.sv
module sim_qlevel_mon;
  localparam int TXS = 5, RXS = 4, IBN = 16, CRN = 8;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [8:0] cmd_free_lvl = 0, resp_lvl = 0, ibi_lvl = 0;
  logic [10:0] tx_lvl = 0, rx_lvl = 0;
  logic cmd_rdy, resp_rdy, ibi_hit, tx_hit, rx_hit;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_q;
  logic [31:0] m_d;

  always #5 clk = ~clk;

  qlevel_mon #(.TX_SZ_CODE(TXS), .RX_SZ_CODE(RXS), .IBI_ENTRIES(IBN),
               .CR_ENTRIES(CRN), .QLW(9), .DLW(11), .AW(8)) u0 (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .cmd_free_lvl, .resp_lvl, .ibi_lvl, .tx_lvl, .rx_lvl,
    .cmd_rdy, .resp_rdy, .ibi_hit, .tx_hit, .rx_hit);

  function automatic int eff(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic bit exp_tx(input int lvl, input int code);
    int cap, fr;
    cap = 2 << TXS;
    fr = (lvl >= cap) ? 0 : cap - lvl;
    return fr >= (1 << code);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags();
    #1;
    chk("R5 cmd_rdy",  32'(cmd_rdy),  32'(int'(cmd_free_lvl) >= eff(int'(m_q[7:0]))));
    chk("R6 resp_rdy", 32'(resp_rdy), 32'(int'(resp_lvl) >= eff(int'(m_q[15:8]))));
    chk("R7 ibi_hit",  32'(ibi_hit),  32'(int'(ibi_lvl) >= eff(int'(m_q[31:24]))));
    chk("R10 tx_hit",  32'(tx_hit),   32'(exp_tx(int'(tx_lvl), int'(m_d[2:0]))));
    chk("R9 rx_hit",   32'(rx_hit),   32'(int'(rx_lvl) >= (1 << m_d[10:8])));
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a == 8'h10) m_q = d;
    if (a == 8'h14) m_d = d & 32'h0707_0707;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    m_q = 32'h0101_0101; m_d = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd("R1 qthr reset", 8'h10, 32'h0101_0101);
    rd("R1 dthr reset", 8'h14, 32'h0);
    // R3 size register and ignored write
    rd("R3 size", 8'h18, {8'(TXS), 8'(RXS), 8'(IBN), 8'(CRN)});
    wr(8'h18, 32'hFFFF_FFFF);
    rd("R3 size after write", 8'h18, {8'(TXS), 8'(RXS), 8'(IBN), 8'(CRN)});
    // R8 empty queues with reset thresholds
    chk_flags();
    chk("R8 empty cmd", 32'(cmd_rdy), 0);
    // R2 readback
    wr(8'h10, 32'hA5C3_7E19);
    rd("R2 qthr", 8'h10, 32'hA5C3_7E19);
    wr(8'h14, 32'hFFFF_FFFF);
    rd("R2 dthr masked", 8'h14, 32'h0707_0707);
    // R8 zero thresholds act as one
    wr(8'h10, 32'h0);
    cmd_free_lvl = 0; resp_lvl = 0; ibi_lvl = 0;
    chk_flags();
    chk("R8 zero thr empty resp", 32'(resp_rdy), 0);
    cmd_free_lvl = 1; resp_lvl = 1; ibi_lvl = 1;
    chk_flags();
    chk("R8 zero thr one entry ibi", 32'(ibi_hit), 1);
    // R7 data byte has no effect
    wr(8'h10, 32'h03FF_0000);
    ibi_lvl = 3;
    chk_flags();
    chk("R7 data byte ignored", 32'(ibi_hit), 1);
    // R4 status registers
    cmd_free_lvl = 9'h1A5; resp_lvl = 9'h0F3; ibi_lvl = 9'h14C;
    tx_lvl = 11'h5B7; rx_lvl = 11'h2C9;
    rd("R4 qlvl", 8'h38, {3'd0, 9'h14C, 1'b0, 9'h0F3, 1'b0, 9'h1A5});
    rd("R4 dlvl", 8'h3C, {5'd0, 11'h2C9, 5'd0, 11'h5B7});
    // R10 TX boundaries: cap 64, code 5 needs 32 free
    wr(8'h14, 32'h0000_0005);
    tx_lvl = 32; chk_flags(); chk("R10 tx free=32", 32'(tx_hit), 1);
    tx_lvl = 33; chk_flags(); chk("R10 tx free=31", 32'(tx_hit), 0);
    tx_lvl = 200; chk_flags(); chk("R10 tx over cap", 32'(tx_hit), 0);
    wr(8'h14, 32'h0000_0000);
    tx_lvl = 63; chk_flags(); chk("R10 tx free=1", 32'(tx_hit), 1);
    tx_lvl = 64; chk_flags(); chk("R10 tx at cap", 32'(tx_hit), 0);
    // R9 RX boundaries: code 3 needs 8
    wr(8'h14, 32'h0000_0300);
    rx_lvl = 7; chk_flags(); chk("R9 rx 7", 32'(rx_hit), 0);
    rx_lvl = 8; chk_flags(); chk("R9 rx 8", 32'(rx_hit), 1);
    // R12 unmapped
    rd("R12 unmapped read", 8'h20, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);
    rd("R12 qthr kept", 8'h10, m_q);
    rd("R12 dthr kept", 8'h14, m_d);
    // R11 same-cycle write and level change
    wr(8'h10, 32'h0101_0101);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h10; reg_wdata = 32'h0101_0401; resp_lvl = 3;
    #1; chk("R11 old thr before edge", 32'(resp_rdy), 1);
    @(negedge clk);
    reg_we = 0; m_q = 32'h0101_0401;
    #1; chk("R11 new thr after edge", 32'(resp_rdy), 0);
    resp_lvl = 4;
    chk_flags();
    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) wr(8'h10, {8'($urandom % 6), 8'($urandom), 8'($urandom % 6), 8'($urandom % 6)});
      else if (op == 1) wr(8'h14, $urandom);
      else begin
        @(negedge clk);
        cmd_free_lvl = 9'($urandom % 9);
        resp_lvl = 9'($urandom % 9);
        ibi_lvl = 9'($urandom % 9);
        tx_lvl = 11'($urandom % 80);
        rx_lvl = 11'($urandom % 160);
      end
      chk_flags();
      if (op < 2) begin
        rd("R2 random qthr", 8'h10, m_q);
        rd("R2 random dthr", 8'h14, m_d);
      end
    end
    finish_run();
  end
endmodule